// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the processor-facing side of a serial port. It takes simple single-cycle read and write strobes on word-aligned addresses. Software uses six registers: a transmit data port, a receive data port, a control word, a status word, a pair of interrupt levels, and a baud setting that is passed on to the serial engine. Behind the data ports are two byte FIFOs of 64 entries each. The serial engine drains the transmit FIFO and fills the receive FIFO through byte-wide handshakes. It also reports parity and framing faults as one-cycle strobes.

The block keeps sticky error flags and the FIFO levels. From these it drives a single interrupt line. The error-clear bit and the two FIFO flush bits take effect while they are held at 1. They stay set until software writes them back to 0. Software knows the transmit side is idle when the transmit FIFO is empty and the engine's busy flag is low. These two facts appear as separate status bits.

Top module: `uart_regif`

## Requirements
- R1: After reset, the control, threshold and baud registers read 0. Status reads 0x0050_0000: bit 20 (receive empty) and bit 22 (transmit empty) are set, and all error bits are clear. `irq`, `eng_tx_valid`, `tx_enable` and `rx_enable` are 0.
- R2: A write to offset 0x00 stores bits [7:0] in the transmit FIFO. Control bit 12 enables transmit. While transmit is enabled and the FIFO holds data, `eng_tx_valid` is 1 and `eng_tx_data` shows the oldest byte. An `eng_tx_pop` in that state removes it, so bytes leave in write order. While bit 12 is 0, `eng_tx_valid` stays 0.
- R3: When the transmit FIFO holds 64 bytes, status bit 21 (full) is set. A further write to 0x00 is dropped and sets the sticky status bit 18. Bit 18 stays set until cleared as described in R7.
- R4: Control bit 13 enables receive. With receive enabled, each `eng_rx_push` stores `eng_rx_data` unless the FIFO already holds 64 bytes. A read of offset 0x04 returns the oldest byte in bits [7:0], with zeros above, and removes it. With bit 13 at 0, pushes are ignored.
- R5: A read of 0x04 while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R6: While receive is enabled, `eng_rx_perr` sets the sticky status bit 16 and `eng_rx_ferr` sets the sticky status bit 17. With receive disabled, both strobes are ignored.
- R7: While control bit 24 is 1, status bits 16, 17 and 18 read 0, even when new faults arrive. The bit does not clear itself. Once it returns to 0, the flags stay clear until a new fault occurs.
- R8: While control bit 22 is 1, the transmit FIFO is held empty and writes to 0x00 are discarded. While control bit 23 is 1, the receive FIFO is held empty and pushes are discarded.
- R9: `irq` is the OR of two terms. The receive term is control bit 27 AND (receive count ≥ threshold bits [7:0]). The transmit term is control bit 28 AND (transmit count ≤ threshold bits [15:8]).
- R10: Status bit 25 follows `eng_tx_busy`, independently of status bit 22 (transmit empty).
- R11: Control (offset 0x08) and baud (0x14) read back all 32 written bits. Threshold (0x10) reads back bits [15:0], with zeros above. `tx_enable`, `rx_enable` and `baud_cfg` reflect the stored values. An access with nonzero address bits [1:0] selects no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive FIFO at offset 0x04) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| tx_enable | output | 1 | Control bit 12 |
| rx_enable | output | 1 | Control bit 13 |
| baud_cfg | output | 32 | Stored baud setting |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_data | output | DW | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the offered byte |
| eng_tx_busy | input | 1 | Engine is shifting a byte out |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | DW | Received byte |
| eng_rx_perr | input | 1 | Parity fault strobe |
| eng_rx_ferr | input | 1 | Framing fault strobe |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest conditions to reach from the ports are FIFO boundaries that coincide with the level-held control bits. Examples are a 65th transmit write landing on a full FIFO, a fault strobe arriving while the error-clear bit is still held, and traffic arriving during a held flush. The directed phase builds each of these on purpose: it fills the transmit FIFO with the transmitter disabled and holds the clear and flush bits across new events. A seeded random phase then mixes writes, pops, pushes and reads against random thresholds, so both FIFOs cross full, empty and threshold levels many times. After every step it compares status and `irq` with a bench model.

// File: rtl/uart_regif.sv
module uart_regif #(
  parameter int DEPTH  = 64,
  parameter int DW     = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic [31:0]       baud_cfg,
  output logic              eng_tx_valid,
  output logic [DW-1:0]     eng_tx_data,
  input  logic              eng_tx_pop,
  input  logic              eng_tx_busy,
  input  logic              eng_rx_push,
  input  logic [DW-1:0]     eng_rx_data,
  input  logic              eng_rx_perr,
  input  logic              eng_rx_ferr,
  output logic              irq
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int WA = ADDR_W - 2;

  localparam logic [WA-1:0] W_TXD  = WA'(0);
  localparam logic [WA-1:0] W_RXD  = WA'(1);
  localparam logic [WA-1:0] W_CTL  = WA'(2);
  localparam logic [WA-1:0] W_STA  = WA'(3);
  localparam logic [WA-1:0] W_THR  = WA'(4);
  localparam logic [WA-1:0] W_BAUD = WA'(5);

  localparam int C_TXEN  = 12;
  localparam int C_RXEN  = 13;
  localparam int C_TXRST = 22;
  localparam int C_RXRST = 23;
  localparam int C_CLR   = 24;
  localparam int C_RXIE  = 27;
  localparam int C_TXIE  = 28;

  localparam int S_PERR  = 16;
  localparam int S_FERR  = 17;
  localparam int S_WERR  = 18;
  localparam int S_RXEMP = 20;
  localparam int S_TXFUL = 21;
  localparam int S_TXEMP = 22;
  localparam int S_BUSY  = 25;

  logic [31:0] ctl_q, baud_q;
  logic [15:0] thr_q;
  logic        perr_q, ferr_q, werr_q;

  logic [DW-1:0] txm [DEPTH];
  logic [DW-1:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire [WA-1:0] widx = bus_addr[ADDR_W-1:2];
  wire aligned = (bus_addr[1:0] == 2'b00);
  wire sel_txd = aligned && (widx == W_TXD);
  wire sel_rxd = aligned && (widx == W_RXD);
  wire sel_ctl = aligned && (widx == W_CTL);
  wire sel_thr = aligned && (widx == W_THR);
  wire sel_bd  = aligned && (widx == W_BAUD);

  wire tx_rst   = ctl_q[C_TXRST];
  wire rx_rst   = ctl_q[C_RXRST];
  wire err_clr  = ctl_q[C_CLR];
  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == CW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);

  wire tx_wr   = bus_wr && sel_txd && !tx_rst;
  wire tx_push = tx_wr && !tx_full;
  wire tx_drop = tx_wr && tx_full;
  wire tx_pop  = eng_tx_pop && eng_tx_valid;
  wire rx_push = eng_rx_push && rx_enable && !rx_full && !rx_rst;
  wire rx_pop  = bus_rd && sel_rxd && !rx_empty && !rx_rst;

  assign tx_enable    = ctl_q[C_TXEN];
  assign rx_enable    = ctl_q[C_RXEN];
  assign baud_cfg     = baud_q;
  assign eng_tx_valid = tx_enable && !tx_empty && !tx_rst;
  assign eng_tx_data  = txm[tx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      thr_q  <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctl) ctl_q  <= bus_wdata;
      if (sel_thr) thr_q  <= bus_wdata[15:0];
      if (sel_bd)  baud_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      werr_q <= 1'b0;
    end else if (err_clr) begin
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      if (eng_rx_perr && rx_enable) perr_q <= 1'b1;
      if (eng_rx_ferr && rx_enable) ferr_q <= 1'b1;
      if (tx_drop)                  werr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push) rxm[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (tx_pop)  tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  logic [31:0] sta;
  always_comb begin
    sta          = '0;
    sta[S_PERR]  = perr_q;
    sta[S_FERR]  = ferr_q;
    sta[S_WERR]  = werr_q;
    sta[S_RXEMP] = rx_empty;
    sta[S_TXFUL] = tx_full;
    sta[S_TXEMP] = tx_empty;
    sta[S_BUSY]  = eng_tx_busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        W_RXD:   if (!rx_empty) bus_rdata[DW-1:0] = rxm[rx_rp];
        W_CTL:   bus_rdata = ctl_q;
        W_STA:   bus_rdata = sta;
        W_THR:   bus_rdata = {16'h0, thr_q};
        W_BAUD:  bus_rdata = baud_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  wire rx_irq = ctl_q[C_RXIE] && (32'(rx_cnt) >= 32'(thr_q[7:0]));
  wire tx_irq = ctl_q[C_TXIE] && (32'(tx_cnt) <= 32'(thr_q[15:8]));
  assign irq = rx_irq || tx_irq;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     c_txen,
  input logic                     c_rxen,
  input logic                     c_txrst,
  input logic                     c_rxrst,
  input logic                     c_clr,
  input logic                     c_rxie,
  input logic                     c_txie,
  input logic [$clog2(DEPTH):0]   tx_cnt,
  input logic [$clog2(DEPTH):0]   rx_cnt,
  input logic [2:0]               errs,
  input logic                     irq,
  input logic                     tx_valid,
  input logic                     bus_rd,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     rx_push_in
);
  wire rd_rx = bus_rd && (bus_addr == ADDR_W'(4));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH));

  p_werr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (errs[2] && !c_clr) |=> errs[2]);

  p_txvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (c_txen && tx_cnt != '0));

  p_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rxen && !c_rxrst && !bus_rd) |=> (rx_cnt == $past(rx_cnt)));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_cnt == '0 && !rx_push_in) |=> (rx_cnt == '0));

  p_clr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> (errs == 3'b000));

  p_txflush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c_txrst |=> (tx_cnt == '0));

  p_rxflush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c_rxrst |=> (rx_cnt == '0));

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rxie && !c_txie) |-> !irq);
endmodule

bind uart_regif uart_regif_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .c_txen(ctl_q[12]), .c_rxen(ctl_q[13]), .c_txrst(ctl_q[22]), .c_rxrst(ctl_q[23]),
  .c_clr(ctl_q[24]), .c_rxie(ctl_q[27]), .c_txie(ctl_q[28]),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .errs({werr_q, ferr_q, perr_q}),
  .irq(irq), .tx_valid(eng_tx_valid), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .rx_push_in(eng_rx_push)
);

// File: tb/sim_uart_regif.sv
`timescale 1ns/1ps
module sim_uart_regif;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, baud_cfg;
  logic tx_enable, rx_enable, eng_tx_valid, irq;
  logic [7:0] eng_tx_data, eng_rx_data = '0;
  logic eng_tx_pop = 0, eng_tx_busy = 0, eng_rx_push = 0, eng_rx_perr = 0, eng_rx_ferr = 0;

  always #2 clk = ~clk;

  uart_regif u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .baud_cfg(baud_cfg),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
    .eng_tx_busy(eng_tx_busy), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_rx_perr(eng_rx_perr), .eng_rx_ferr(eng_rx_ferr), .irq(irq));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mtx[$], mrx[$];
  logic [31:0] cur_ctl = 0, cur_thr = 0;
  bit pe = 0, fe = 0, we = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_sta();
    logic [31:0] s = 0;
    s[16] = pe; s[17] = fe; s[18] = we;
    s[20] = (mrx.size() == 0);
    s[21] = (mtx.size() == 64);
    s[22] = (mtx.size() == 0);
    s[25] = eng_tx_busy;
    return s;
  endfunction

  function automatic bit exp_irq();
    return (cur_ctl[27] && mrx.size() >= int'(cur_thr[7:0])) ||
           (cur_ctl[28] && mtx.size() <= int'(cur_thr[15:8]));
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_ctl(input logic [31:0] v);
    wr(5'd8, v); cur_ctl = v;
    if (v[24]) begin pe = 0; fe = 0; we = 0; end
    if (v[22]) mtx.delete();
    if (v[23]) mrx.delete();
  endtask

  task automatic set_thr(input logic [15:0] v);
    wr(5'd16, {16'h0, v}); cur_thr = {16'h0, v};
  endtask

  task automatic m_wtx(input logic [7:0] b);
    wr(5'd0, {24'hFFFFFF, b});
    if (!cur_ctl[22]) begin
      if (mtx.size() < 64) mtx.push_back(b);
      else if (!cur_ctl[24]) we = 1;
    end
  endtask

  task automatic m_push(input logic [7:0] b, input bit p, input bit f);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = b; eng_rx_perr = p; eng_rx_ferr = f;
    @(negedge clk); eng_rx_push = 0; eng_rx_perr = 0; eng_rx_ferr = 0;
    if (cur_ctl[13] && !cur_ctl[23] && mrx.size() < 64) mrx.push_back(b);
    if (cur_ctl[13] && !cur_ctl[24]) begin
      if (p) pe = 1;
      if (f) fe = 1;
    end
  endtask

  task automatic m_rrx(input string req);
    logic [31:0] d, e;
    rd(5'd4, d);
    e = (mrx.size() > 0 && !cur_ctl[23]) ? {24'h0, mrx.pop_front()} : 32'h0;
    chk(d === e, req, d, e);
  endtask

  task automatic m_take(input string req);
    logic v; logic [7:0] d; logic ev; logic [7:0] e;
    @(negedge clk); #1 v = eng_tx_valid; d = eng_tx_data; eng_tx_pop = 1;
    @(negedge clk); eng_tx_pop = 0;
    ev = cur_ctl[12] && mtx.size() > 0;
    chk(v === ev, req, {31'h0, v}, {31'h0, ev});
    if (ev && v === 1'b1) begin
      e = mtx.pop_front();
      chk(d === e, req, {24'h0, d}, {24'h0, e});
    end
  endtask

  task automatic chk_sta(input string req);
    logic [31:0] d;
    rd(5'd12, d);
    chk(d === exp_sta(), req, d, exp_sta());
  endtask

  task automatic chk_irq(input string req);
    #1 chk(irq === exp_irq(), req, {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'd12, d); chk(d === 32'h0050_0000, "R1 status", d, 32'h0050_0000);
    rd(5'd8, d);  chk(d === 32'h0, "R1 control", d, 0);
    #1 chk({irq, eng_tx_valid, tx_enable, rx_enable} === 4'b0, "R1 outputs",
           {28'h0, irq, eng_tx_valid, tx_enable, rx_enable}, 0);

    // R11 readback
    set_ctl(32'h1800_3000);
    rd(5'd8, d); chk(d === 32'h1800_3000, "R11 control", d, 32'h1800_3000);
    wr(5'd16, 32'hABCD_2001); cur_thr = 32'h2001;
    rd(5'd16, d); chk(d === 32'h0000_2001, "R11 threshold", d, 32'h2001);
    wr(5'd20, 32'h1234_5678);
    rd(5'd20, d); chk(d === 32'h1234_5678, "R11 baud", d, 32'h1234_5678);
    chk(baud_cfg === 32'h1234_5678, "R11 baud_cfg", baud_cfg, 32'h1234_5678);
    chk(tx_enable && rx_enable, "R11 enables", {30'h0, tx_enable, rx_enable}, 3);
    wr(5'd21, 32'hDEAD_BEEF);
    rd(5'd20, d); chk(d === 32'h1234_5678, "R11 misaligned write", d, 32'h1234_5678);
    chk_irq("R9 tx level");

    // R2 ordering and enable gating
    set_ctl(32'h0000_2000);
    m_wtx(8'hA1); m_wtx(8'hB2); m_wtx(8'hC3);
    m_take("R2 disabled");
    chk_sta("R2 status");
    set_ctl(32'h0000_3000);
    repeat (4) m_take("R2 order");
    chk_sta("R2 drained");

    // R3 full and overflow
    set_ctl(32'h0000_2000);
    for (int i = 0; i < 64; i++) m_wtx(8'(i * 3 + 1));
    chk_sta("R3 full");
    m_wtx(8'hEE);
    chk_sta("R3 write error");
    set_ctl(32'h0000_3000);
    for (int i = 0; i < 65; i++) m_take("R3 drain");
    chk_sta("R3 sticky");

    // R7 level-held clear
    set_ctl(32'h0100_3000);
    chk_sta("R7 cleared");
    m_push(8'h55, 1, 1);
    chk_sta("R7 held");
    set_ctl(32'h0000_3000);
    chk_sta("R7 released");
    m_rrx("R7 data");

    // R6 sticky faults
    m_push(8'h11, 1, 0);
    m_push(8'h22, 0, 1);
    m_push(8'h33, 0, 0);
    chk_sta("R6 sticky");
    repeat (3) m_rrx("R4 order");
    set_ctl(32'h0100_3000); set_ctl(32'h0000_3000);

    // R5 empty read, R4 disabled
    m_rrx("R5 empty read");
    chk_sta("R5 unchanged");
    set_ctl(32'h0000_1000);
    m_push(8'h77, 1, 1);
    chk_sta("R4 R6 disabled");
    m_rrx("R4 disabled read");

    // R8 held flush
    set_ctl(32'h0000_2000);
    m_wtx(8'h01); m_wtx(8'h02); m_push(8'h03, 0, 0);
    set_ctl(32'h00C0_2000);
    m_wtx(8'h04); m_push(8'h05, 0, 0);
    chk_sta("R8 held");
    set_ctl(32'h0000_2000);
    chk_sta("R8 released");
    m_rrx("R8 rx empty");

    // R10 busy separate from empty
    eng_tx_busy = 1;
    chk_sta("R10 busy");
    eng_tx_busy = 0;
    chk_sta("R10 idle");

    // R9 thresholds
    set_thr(16'h0203);
    set_ctl(32'h0800_2000);
    m_push(8'hA0, 0, 0); m_push(8'hA1, 0, 0); chk_irq("R9 rx below");
    m_push(8'hA2, 0, 0); chk_irq("R9 rx at");
    set_ctl(32'h1080_2000); set_ctl(32'h1000_2000);
    chk_irq("R9 tx empty");
    m_wtx(8'h10); m_wtx(8'h11); chk_irq("R9 tx at");
    m_wtx(8'h12); chk_irq("R9 tx above");
    set_ctl(32'h00C0_0000); set_ctl(32'h1800_3000);

    // random mix
    set_thr({8'($urandom_range(0, 70)), 8'($urandom_range(1, 70))});
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 9);
      if (i % 300 == 299) set_thr({8'($urandom_range(0, 70)), 8'($urandom_range(0, 70))});
      case (op)
        0, 1, 2: m_wtx(8'($urandom));
        3, 4:    m_take("R2 random");
        5, 6, 7: m_push(8'($urandom), ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
        default: m_rrx("R4 random");
      endcase
      chk_irq("R9 random");
      if (i % 5 == 0) chk_sta("R3 random status");
    end
    finish_up();
  end
endmodule